// File: doc/BRIEF.md
# Edge-Counting Timer

This block is a timer/counter with a configurable width, run from one peripheral clock. It has two count sources. In clock-driven operation, a prescale counter runs from zero up to a programmable limit. Each time that counter wraps, the main count register steps by one. In edge-driven operation, one of several external pins is chosen. Each chosen transition on that pin (rising, falling or either) steps the main count register directly, without passing through the prescaler.

Software reaches the block through a flat register port. Writes are strobed and reads are combinational. The port gives access to these registers:

- a control word, holding the run bit and the hold-in-clear bit;
- a source word, holding the mode and the pin select;
- the prescale limit;
- read-only views of both counters.

Edges are found by comparing two successive samples of the selected pin, taken on the clock. For this reason, an input level must last at least one clock period to be seen.

Top module: `edge_timer`

## Requirements
- R1: After the asynchronous reset, every register reads zero: control, source, prescale limit, main count and prescale count.
- R2: Register addresses are 0 for control, 1 for source, 2 for prescale limit, 3 for main count and 4 for prescale count. Control bit 0 is the run bit and bit 1 is the clear bit. In the source word, bits 1:0 hold the mode and bits 3:2 hold the pin select. Reading back gives only these bits, with all other bits at zero. The prescale limit reads back at full width. Addresses 5 to 7 read zero. Writes to the two count addresses have no effect.
- R3: In mode 00 with the run bit set, each clock edge works as follows. If the prescale count equals the limit, it clears the prescale count and increments the main count. Otherwise it increments the prescale count. With a limit of P, after N counting edges the main count is N/(P+1) and the prescale count is N mod (P+1).
- R4: While the run bit is zero, both counters hold their values.
- R5: While the clear bit is set, both counters are forced to zero on every clock edge, whatever the run bit is.
- R6: In mode 01, each rising transition of the selected pin increments the main count by one. The prescale count stays at zero.
- R7: In mode 10, each falling transition of the selected pin increments the main count by one.
- R8: In mode 11, both rising and falling transitions of the selected pin increment the main count.
- R9: The pin select chooses which input is counted. Transitions on the unselected inputs have no effect.
- R10: Writing a new pin select or mode makes the block reload both stored samples from the newly chosen pin. Because of this, a level difference between the old pin and the new pin is never counted as a transition.
- R11: The main count wraps from all ones to zero.
- R12: A transition that is applied between two clock edges shows up in the main count only after the second rising clock edge that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | CNT_W | Write data |
| cap_i | input | NUM_CAP | External count inputs |
| rdata_o | output | CNT_W | Read data for addr_i |

## Verification
Clock-driven counting is swept over several prescale limits and run lengths. This separates prescale wrap errors from errors in the main-count step, and a narrow count width lets the wrap of the main count be reached.

Edge-driven counting is tried on every pin select with every edge mode. In these runs, the unselected pins pulse more often than the selected one, so a wrong mux choice or a wrong edge polarity gives a count that differs from the expected one.

Further directed sequences cover these cases:

- switching to a pin at a different level, which exposes a false edge;
- a single edge observed cycle by cycle, which pins down the latency;
- the run bit and the clear bit changed in the middle of a count.

// File: rtl/edge_timer_pkg.sv
package edge_timer_pkg;
  typedef enum logic [1:0] {
    MODE_CLOCK = 2'b00,
    MODE_RISE  = 2'b01,
    MODE_FALL  = 2'b10,
    MODE_BOTH  = 2'b11
  } src_mode_e;

  localparam int ADDR_W = 3;
  localparam int SEL_W  = 2;
  localparam int MAX_CAP = 1 << SEL_W;

  localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_SRC  = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_LIM  = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_MAIN = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_PRE  = 3'd4;
endpackage

// File: rtl/edge_timer_regs.sv
module edge_timer_regs
  import edge_timer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] main_i,
  input  logic [DATA_W-1:0] pre_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              run_o,
  output logic              clr_o,
  output src_mode_e         mode_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic [DATA_W-1:0] lim_o
);
  logic              run_q, clr_q;
  src_mode_e         mode_q;
  logic [SEL_W-1:0]  sel_q;
  logic [DATA_W-1:0] lim_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      clr_q  <= 1'b0;
      mode_q <= MODE_CLOCK;
      sel_q  <= '0;
      lim_q  <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        ADR_CTRL: begin
          run_q <= wdata_i[0];
          clr_q <= wdata_i[1];
        end
        ADR_SRC: begin
          mode_q <= src_mode_e'(wdata_i[1:0]);
          sel_q  <= wdata_i[2 +: SEL_W];
        end
        ADR_LIM: lim_q <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADR_CTRL: rdata_o[1:0] = {clr_q, run_q};
      ADR_SRC:  rdata_o[2+SEL_W-1:0] = {sel_q, mode_q};
      ADR_LIM:  rdata_o = lim_q;
      ADR_MAIN: rdata_o = main_i;
      ADR_PRE:  rdata_o = pre_i;
      default:  rdata_o = '0;
    endcase
  end

  assign run_o  = run_q;
  assign clr_o  = clr_q;
  assign mode_o = mode_q;
  assign sel_o  = sel_q;
  assign lim_o  = lim_q;

  AST_CTRL_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADR_CTRL) |-> (rdata_o[DATA_W-1:2] == '0)); // R2
endmodule

// File: rtl/edge_timer_edge.sv
module edge_timer_edge
  import edge_timer_pkg::*;
#(
  parameter int NUM_CAP = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_CAP-1:0] cap_i,
  input  src_mode_e          mode_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic               hit_o
);
  logic [MAX_CAP-1:0] cap_pad;

  for (genvar g = 0; g < MAX_CAP; g++) begin : g_pad
    if (g < NUM_CAP) begin : g_used
      assign cap_pad[g] = cap_i[g];
    end else begin : g_tie
      assign cap_pad[g] = 1'b0;
    end
  end

  logic               pin;
  logic [SEL_W+1:0]   cfg, cfg_q;
  logic               reload;
  logic               cur_q, prev_q;
  logic               rise, fall;

  assign pin    = cap_pad[sel_i];
  assign cfg    = {sel_i, mode_i};
  assign reload = (cfg != cfg_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      cur_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      cfg_q <= cfg;
      cur_q <= pin;
      // on a source change both samples come from the new pin
      prev_q <= reload ? pin : cur_q;
    end
  end

  assign rise = cur_q & ~prev_q;
  assign fall = ~cur_q & prev_q;

  always_comb begin
    case (mode_i)
      MODE_RISE: hit_o = rise;
      MODE_FALL: hit_o = fall;
      MODE_BOTH: hit_o = rise | fall;
      default:   hit_o = 1'b0;
    endcase
  end

  AST_RELOAD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload |=> !(rise || fall)); // R10
endmodule

// File: rtl/edge_timer_count.sv
module edge_timer_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic             clock_mode_i,
  input  logic             hit_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic [CNT_W-1:0] main_o,
  output logic [CNT_W-1:0] pre_o
);
  logic [CNT_W-1:0] main_q, pre_q;
  logic             wrap;

  assign wrap = (pre_q == lim_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      main_q <= '0;
      pre_q  <= '0;
    end else if (clr_i) begin
      main_q <= '0;
      pre_q  <= '0;
    end else if (run_i) begin
      if (clock_mode_i) begin
        if (wrap) begin
          pre_q  <= '0;
          main_q <= main_q + 1'b1;
        end else begin
          pre_q <= pre_q + 1'b1;
        end
      end else if (hit_i) begin
        main_q <= main_q + 1'b1;
      end
    end
  end

  assign main_o = main_q;
  assign pre_o  = pre_q;

  AST_CLR_ZEROES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (main_o == '0 && pre_o == '0)); // R5
  AST_HOLD_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !clr_i) |=> ($stable(main_o) && $stable(pre_o))); // R4
  AST_EDGE_NO_PRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !clr_i && !clock_mode_i) |=> $stable(pre_o)); // R6
  AST_MAIN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !clr_i) |=> (main_o == $past(main_o) ||
                           main_o == CNT_W'($past(main_o) + 1'b1))); // R3
endmodule

// File: rtl/edge_timer.sv
module edge_timer
  import edge_timer_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int NUM_CAP = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [CNT_W-1:0]   wdata_i,
  input  logic [NUM_CAP-1:0] cap_i,
  output logic [CNT_W-1:0]   rdata_o
);
  logic             run, clr, hit;
  src_mode_e        mode;
  logic [SEL_W-1:0] sel;
  logic [CNT_W-1:0] lim, main_cnt, pre_cnt;

  edge_timer_regs #(.DATA_W(CNT_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .main_i  (main_cnt),
    .pre_i   (pre_cnt),
    .rdata_o (rdata_o),
    .run_o   (run),
    .clr_o   (clr),
    .mode_o  (mode),
    .sel_o   (sel),
    .lim_o   (lim)
  );

  edge_timer_edge #(.NUM_CAP(NUM_CAP)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (cap_i),
    .mode_i (mode),
    .sel_i  (sel),
    .hit_o  (hit)
  );

  edge_timer_count #(.CNT_W(CNT_W)) u_count (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .run_i        (run),
    .clr_i        (clr),
    .clock_mode_i (mode == MODE_CLOCK),
    .hit_i        (hit),
    .lim_i        (lim),
    .main_o       (main_cnt),
    .pre_o        (pre_cnt)
  );
endmodule

// File: tb/edge_timer_tb_top.sv
module edge_timer_tb_top;
  localparam int CNT_W   = 8;
  localparam int NUM_CAP = 4;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               wr_en;
  logic [2:0]         addr;
  logic [CNT_W-1:0]   wdata;
  logic [NUM_CAP-1:0] cap;
  logic [CNT_W-1:0]   rdata;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  edge_timer #(.CNT_W(CNT_W), .NUM_CAP(NUM_CAP)) dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .wr_en_i (wr_en),
    .addr_i  (addr),
    .wdata_i (wdata),
    .cap_i   (cap),
    .rdata_o (rdata)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    addr = 3'(a); wdata = CNT_W'(d); wr_en = 1'b1;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  // combinational read, consumes no clock edge
  task automatic rd(input int a, output int v);
    addr = 3'(a);
    #1 v = int'(rdata);
  endtask

  task automatic restart();
    wr(0, 2);
    wr(0, 1);
  endtask

  initial begin
    int v;
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0; cap = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(a, v); check("R1", v, 0);
    end

    // R2 register map and reserved bits
    wr(0, 8'hFF); rd(0, v); check("R2 ctrl", v, 3);
    wr(0, 0);
    wr(1, 8'hFF); rd(1, v); check("R2 src", v, 8'h0F);
    wr(1, 0);
    wr(2, 8'hA5); rd(2, v); check("R2 lim", v, 8'hA5);
    for (int a = 5; a < 8; a++) begin
      rd(a, v); check("R2 unused", v, 0);
    end
    wr(3, 8'h55); wr(4, 8'h33);
    rd(3, v); check("R2 main ro", v, 0);
    rd(4, v); check("R2 pre ro", v, 0);

    // R3 clock mode sweep
    for (int p = 0; p < 4; p++) begin
      for (int n = 0; n < 10; n++) begin
        wr(2, p);
        restart();
        repeat (n) @(posedge clk);
        @(negedge clk);
        rd(3, v); check("R3 main", v, n / (p + 1));
        rd(4, v); check("R3 pre", v, n % (p + 1));
      end
    end

    // R4 hold while stopped
    wr(2, 2);
    restart();
    repeat (6) @(posedge clk);
    wr(0, 0);                       // its edge is the 7th counting edge
    repeat (10) @(posedge clk);
    @(negedge clk);
    rd(3, v); check("R4 main", v, 2);
    rd(4, v); check("R4 pre", v, 1);
    wr(0, 1);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rd(3, v); check("R4 resume", v, 3);
    rd(4, v); check("R4 resume pre", v, 0);

    // R5 clear wins over run
    wr(0, 3);
    repeat (5) @(posedge clk);
    @(negedge clk);
    rd(3, v); check("R5 main", v, 0);
    rd(4, v); check("R5 pre", v, 0);
    wr(0, 1);
    repeat (4) @(posedge clk);
    @(negedge clk);
    rd(3, v); check("R5 after", v, 1);
    rd(4, v); check("R5 after pre", v, 1);

    // R11 wrap
    wr(2, 0);
    restart();
    repeat (255) @(posedge clk);
    @(negedge clk); rd(3, v); check("R11 top", v, 255);
    @(posedge clk); @(negedge clk); rd(3, v); check("R11 wrap", v, 0);
    @(posedge clk); @(negedge clk); rd(3, v); check("R11 next", v, 1);

    // R6 R7 R8 R9 edge modes on every select; other pins pulse more often
    for (int s = 0; s < NUM_CAP; s++) begin
      for (int m = 1; m < 4; m++) begin
        int k;
        k = s + 1;
        cap = '0;
        wr(1, (s << 2) | m);
        restart();
        for (int j = 0; j < 6; j++) begin
          @(negedge clk);
          cap = '1;
          cap[s] = (j < k);
          repeat (2) @(posedge clk);
          @(negedge clk);
          cap = '0;
          repeat (2) @(posedge clk);
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rd(3, v);
        if (m == 1) check("R6 rise R9", v, k);
        else if (m == 2) check("R7 fall R9", v, k);
        else check("R8 both R9", v, 2 * k);
        rd(4, v); check("R6 pre idle", v, 0);
      end
    end

    // R12 latency of one edge
    cap = '0;
    wr(1, (0 << 2) | 1);
    restart();
    @(negedge clk) cap[0] = 1'b1;
    @(posedge clk); @(negedge clk);
    rd(3, v); check("R12 first edge", v, 0);
    @(posedge clk); @(negedge clk);
    rd(3, v); check("R12 second edge", v, 1);

    // R10 no false edge on source change
    cap = 4'b0010;
    wr(1, (0 << 2) | 1);
    restart();
    repeat (3) @(posedge clk);
    wr(1, (1 << 2) | 1);
    repeat (4) @(posedge clk);
    @(negedge clk);
    rd(3, v); check("R10 sel change", v, 0);
    wr(1, (1 << 2) | 2);
    repeat (3) @(posedge clk);
    @(negedge clk) cap[1] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rd(3, v); check("R10 live after", v, 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule